// File: doc/BRIEF.md
# Store Buffer with Age-Colored Load Conflict Search

This block holds the stores of a memory ordering unit from the moment they are allocated until they are written to memory. Each store gets a sequential identifier when it is allocated. Its address and its data arrive later, as two separate operations in either order, and each one names the store by that identifier. A load comes in with a color: the identifier of the youngest store allocated ahead of it in program order. The block compares the load's byte range only with stores of that color or older. One cycle later it reports one of three results. The load may take its data from a store, it must wait, or it may go straight to the cache.

Retirement marks stores as senior, oldest first. Senior stores leave the buffer in program order, one per cycle, on a memory write port. A write goes out only when the memory bus is idle, or when every slot of the buffer is occupied. A flush throws away all speculative (non-senior) stores and moves the allocation point back to just after the youngest senior store.

An identifier is a number from 0 to 2*DEPTH-1. Its value is generation*DEPTH + slot, so it carries one generation bit above the slot number. This lets the age order be decided correctly even after the slot numbers wrap around.

Top module: `sbc_store_buffer`

## Requirements
- R1: After reset the first identifier granted is 0. Each granted allocation advances alloc_id by one, wrapping from 2*DEPTH-1 to 0. alloc_ok is low while DEPTH stores are held, and a request made then is refused without changing alloc_id.
- R2: The result of a load appears one cycle after ld_valid, with res_valid high. res_kind uses the encoding 0 = clear to access cache, 1 = forwarded, 2 = blocked. res_data is zero unless the result is forwarded.
- R3: A store younger than the load's color is never considered. Its age is measured as (color - id) mod 2*DEPTH being DEPTH or more. Such a store has no effect on the result.
- R4: A load is forwarded only when all of these hold for the store that decides it: it starts at the same address, the load size is not larger than the store size, and the store's address and data are both known. Sizes are encoded as 2^size bytes. res_data then holds the low 8*2^size bits of the store data, and the bits above are zero.
- R5: If an older store overlaps the load's byte range but starts at a different address, or is smaller than the load, the load is blocked.
- R6: If an older store's address is still unknown, or it matches the load but its data is still unknown, the load is blocked.
- R7: When several older stores are candidates, only the youngest of them decides the result and supplies the data.
- R8: Each retire request marks the oldest non-senior store as senior. Senior stores are written out in allocation order, one per cycle, with their address, size and data. A write happens only when bus_idle is high or the buffer is full.
- R9: A store that has not been retired is never written out, even when the bus is idle.
- R10: A flush removes every non-senior store, keeps the senior ones, and makes the next identifier the one just after the youngest senior store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request to allocate a store |
| alloc_ok | output | 1 | A free slot exists |
| alloc_id | output | ID_W | Identifier that the next granted allocation receives |
| sta_valid | input | 1 | Store address operation valid |
| sta_id | input | ID_W | Store that the address belongs to |
| sta_addr | input | ADDR_W | Store start byte address |
| sta_size | input | 2 | Store size code (2^size bytes) |
| std_valid | input | 1 | Store data operation valid |
| std_id | input | ID_W | Store that the data belongs to |
| std_data | input | DATA_W | Store data, lowest address in the low byte |
| ret_valid | input | 1 | Retire the oldest non-senior store |
| flush | input | 1 | Discard all non-senior stores |
| ld_valid | input | 1 | Load lookup valid |
| ld_color | input | ID_W | Identifier of the youngest store preceding the load |
| ld_addr | input | ADDR_W | Load start byte address |
| ld_size | input | 2 | Load size code |
| res_valid | output | 1 | Lookup result valid |
| res_kind | output | 2 | 0 clear, 1 forwarded, 2 blocked |
| res_data | output | DATA_W | Forwarded data |
| bus_idle | input | 1 | Memory bus is free |
| mem_wr_valid | output | 1 | A senior store is written this cycle |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_size | output | 2 | Write size code |
| mem_wr_data | output | DATA_W | Write data |

## Verification
The search is exercised with a single store against loads at the same start (smaller, equal and larger size), with a load that overlaps from a different start, and with a load at the adjacent address. Together these separate forwarding from blocking from clearing on the address and size rules alone. Identical loads are also issued with different colors, and one store is observed before its address, then before its data, and then complete. This shows that younger stores are ignored and that missing parts block. Two stores at one address are read with colors on either side of the younger one, which shows that the youngest candidate supplies the data. For draining, the bench toggles bus_idle with and without retired stores, fills all slots so that identifiers wrap, and flushes with both senior and speculative entries present. This shows the ordering of writes, the gating conditions, and the rewind point.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int unsigned SIZE_W = 2;

    typedef enum logic [1:0] {
        LD_CLEAR = 2'd0,
        LD_FWD   = 2'd1,
        LD_BLOCK = 2'd2
    } ld_kind_e;

    typedef struct packed {
        logic valid;
        logic senior;
        logic addr_ok;
        logic data_ok;
    } ent_flags_t;

    // next identifier in a ring of n values
    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned n);
        return (p + 1 == n) ? 0 : p + 1;
    endfunction

    // how many steps 'older' lies behind 'younger' in a ring of n values
    function automatic int unsigned age_gap(input int unsigned younger, input int unsigned older,
                                            input int unsigned n);
        return (younger + n - older) % n;
    endfunction

    // buffer slot addressed by an identifier
    function automatic int unsigned slot_of(input int unsigned p, input int unsigned depth);
        return (p >= depth) ? p - depth : p;
    endfunction

endpackage

// File: rtl/sbc_ptr_ctrl.sv
module sbc_ptr_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned DEPTH = 12,
    parameter int unsigned ID_W  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc_req,
    input  logic            flush,
    input  logic            ret_req,
    input  logic            drain_fire,
    output logic [ID_W-1:0] head_id,
    output logic [ID_W-1:0] ret_id,
    output logic [ID_W-1:0] tail_id,
    output logic            full,
    output logic            alloc_fire,
    output logic            retire_fire
);
    localparam int unsigned NIDS = 2 * DEPTH;

    logic [ID_W-1:0] head_q, ret_q, tail_q;
    int unsigned     used;

    always_comb begin
        used        = age_gap(32'(tail_q), 32'(head_q), NIDS);
        full        = (used == DEPTH);
        alloc_fire  = alloc_req && !full && !flush;
        retire_fire = ret_req && !flush && (ret_q != tail_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            ret_q  <= '0;
            tail_q <= '0;
        end else begin
            if (drain_fire)
                head_q <= ID_W'(wrap_inc(32'(head_q), NIDS));
            if (retire_fire)
                ret_q <= ID_W'(wrap_inc(32'(ret_q), NIDS));
            if (flush)
                tail_q <= ret_q;
            else if (alloc_fire)
                tail_q <= ID_W'(wrap_inc(32'(tail_q), NIDS));
        end
    end

    assign head_id = head_q;
    assign ret_id  = ret_q;
    assign tail_id = tail_q;

endmodule

// File: rtl/sbc_entry_file.sv
module sbc_entry_file
    import sbc_pkg::*;
#(
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  logic [ID_W-1:0]   tail_id,
    input  logic              sta_valid,
    input  logic [ID_W-1:0]   sta_id,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic [SIZE_W-1:0] sta_size,
    input  logic              std_valid,
    input  logic [ID_W-1:0]   std_id,
    input  logic [DATA_W-1:0] std_data,
    input  logic              retire_fire,
    input  logic [ID_W-1:0]   ret_id,
    input  logic              drain_fire,
    input  logic [ID_W-1:0]   head_id,
    input  logic              flush,
    output ent_flags_t        ent_flags [DEPTH],
    output logic [ID_W-1:0]   ent_id    [DEPTH],
    output logic [ADDR_W-1:0] ent_addr  [DEPTH],
    output logic [SIZE_W-1:0] ent_size  [DEPTH],
    output logic [DATA_W-1:0] ent_data  [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam int unsigned SLOT = g;

        ent_flags_t        flags_q;
        logic [ID_W-1:0]   id_q;
        logic [ADDR_W-1:0] addr_q;
        logic [SIZE_W-1:0] size_q;
        logic [DATA_W-1:0] data_q;
        logic              take_alloc, take_drain, open_for_ops;

        always_comb begin
            take_alloc   = alloc_fire && (slot_of(32'(tail_id), DEPTH) == SLOT);
            take_drain   = drain_fire && (slot_of(32'(head_id), DEPTH) == SLOT);
            open_for_ops = flags_q.valid && !flags_q.senior;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q <= '0;
                id_q    <= '0;
                addr_q  <= '0;
                size_q  <= '0;
                data_q  <= '0;
            end else if (take_alloc) begin
                flags_q       <= '0;
                flags_q.valid <= 1'b1;
                id_q          <= tail_id;
            end else begin
                if (sta_valid && open_for_ops && (sta_id == id_q)) begin
                    addr_q          <= sta_addr;
                    size_q          <= sta_size;
                    flags_q.addr_ok <= 1'b1;
                end
                if (std_valid && open_for_ops && (std_id == id_q)) begin
                    data_q          <= std_data;
                    flags_q.data_ok <= 1'b1;
                end
                if (retire_fire && flags_q.valid && (ret_id == id_q))
                    flags_q.senior <= 1'b1;
                if (take_drain) begin
                    flags_q.valid  <= 1'b0;
                    flags_q.senior <= 1'b0;
                end
                if (flush && !flags_q.senior)
                    flags_q.valid <= 1'b0;
            end
        end

        assign ent_flags[g] = flags_q;
        assign ent_id[g]    = id_q;
        assign ent_addr[g]  = addr_q;
        assign ent_size[g]  = size_q;
        assign ent_data[g]  = data_q;
    end

endmodule

// File: rtl/sbc_conflict_search.sv
module sbc_conflict_search
    import sbc_pkg::*;
#(
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 64
) (
    input  logic [ID_W-1:0]   ld_color,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  ent_flags_t        ent_flags [DEPTH],
    input  logic [ID_W-1:0]   ent_id    [DEPTH],
    input  logic [ADDR_W-1:0] ent_addr  [DEPTH],
    input  logic [SIZE_W-1:0] ent_size  [DEPTH],
    input  logic [DATA_W-1:0] ent_data  [DEPTH],
    output ld_kind_e          kind,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned NIDS  = 2 * DEPTH;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    function automatic logic spans_touch(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] sa,
                                         input logic [ADDR_W-1:0] b, input logic [SIZE_W-1:0] sb);
        logic [ADDR_W:0] a_lo, a_hi, b_lo, b_hi;
        a_lo = {1'b0, a};
        b_lo = {1'b0, b};
        a_hi = a_lo + ((ADDR_W+1)'(1) << sa);
        b_hi = b_lo + ((ADDR_W+1)'(1) << sb);
        return (a_lo < b_hi) && (b_lo < a_hi);
    endfunction

    logic              found;
    logic [IDX_W-1:0]  pick;
    int unsigned       best_gap;
    int unsigned       gap;
    logic              cand;
    logic [DATA_W-1:0] keep;

    always_comb begin
        found    = 1'b0;
        pick     = '0;
        best_gap = NIDS;
        for (int i = 0; i < DEPTH; i++) begin
            gap  = age_gap(32'(ld_color), 32'(ent_id[i]), NIDS);
            cand = ent_flags[i].valid && (gap < DEPTH) &&
                   (!ent_flags[i].addr_ok ||
                    spans_touch(ld_addr, ld_size, ent_addr[i], ent_size[i]));
            if (cand && (gap < best_gap)) begin
                best_gap = gap;
                pick     = IDX_W'(i);
                found    = 1'b1;
            end
        end

        if ((32'(8) << ld_size) >= DATA_W)
            keep = '1;
        else
            keep = (DATA_W'(1) << (32'(8) << ld_size)) - DATA_W'(1);

        kind = LD_CLEAR;
        data = '0;
        if (found) begin
            if (ent_flags[pick].addr_ok && ent_flags[pick].data_ok &&
                (ent_addr[pick] == ld_addr) && (ld_size <= ent_size[pick])) begin
                kind = LD_FWD;
                data = ent_data[pick] & keep;
            end else begin
                kind = LD_BLOCK;
            end
        end
    end

endmodule

// File: rtl/sbc_store_buffer.sv
module sbc_store_buffer
    import sbc_pkg::*;
#(
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned ID_W  = $clog2(2 * DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic              alloc_ok,
    output logic [ID_W-1:0]   alloc_id,
    input  logic              sta_valid,
    input  logic [ID_W-1:0]   sta_id,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic [1:0]        sta_size,
    input  logic              std_valid,
    input  logic [ID_W-1:0]   std_id,
    input  logic [DATA_W-1:0] std_data,
    input  logic              ret_valid,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic [ID_W-1:0]   ld_color,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [DATA_W-1:0] res_data,
    input  logic              bus_idle,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [1:0]        mem_wr_size,
    output logic [DATA_W-1:0] mem_wr_data
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [ID_W-1:0]   head_id, ret_id, tail_id;
    logic              full, alloc_fire, retire_fire, drain_fire;
    logic [IDX_W-1:0]  head_slot;

    ent_flags_t        ent_flags [DEPTH];
    logic [ID_W-1:0]   ent_id    [DEPTH];
    logic [ADDR_W-1:0] ent_addr  [DEPTH];
    logic [SIZE_W-1:0] ent_size  [DEPTH];
    logic [DATA_W-1:0] ent_data  [DEPTH];

    ld_kind_e          srch_kind, res_kind_q;
    logic [DATA_W-1:0] srch_data;

    sbc_ptr_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (alloc_req),
        .flush      (flush),
        .ret_req    (ret_valid),
        .drain_fire (drain_fire),
        .head_id    (head_id),
        .ret_id     (ret_id),
        .tail_id    (tail_id),
        .full       (full),
        .alloc_fire (alloc_fire),
        .retire_fire(retire_fire)
    );

    sbc_entry_file #(.DEPTH(DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entries (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .tail_id    (tail_id),
        .sta_valid  (sta_valid),
        .sta_id     (sta_id),
        .sta_addr   (sta_addr),
        .sta_size   (sta_size),
        .std_valid  (std_valid),
        .std_id     (std_id),
        .std_data   (std_data),
        .retire_fire(retire_fire),
        .ret_id     (ret_id),
        .drain_fire (drain_fire),
        .head_id    (head_id),
        .flush      (flush),
        .ent_flags  (ent_flags),
        .ent_id     (ent_id),
        .ent_addr   (ent_addr),
        .ent_size   (ent_size),
        .ent_data   (ent_data)
    );

    sbc_conflict_search #(.DEPTH(DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
        .ld_color (ld_color),
        .ld_addr  (ld_addr),
        .ld_size  (ld_size),
        .ent_flags(ent_flags),
        .ent_id   (ent_id),
        .ent_addr (ent_addr),
        .ent_size (ent_size),
        .ent_data (ent_data),
        .kind     (srch_kind),
        .data     (srch_data)
    );

    // oldest entry leaves when it is senior and the bus is free or no slot is left
    always_comb begin
        head_slot  = IDX_W'(slot_of(32'(head_id), DEPTH));
        drain_fire = ent_flags[head_slot].valid && ent_flags[head_slot].senior &&
                     (bus_idle || full);
    end

    assign mem_wr_valid = drain_fire;
    assign mem_wr_addr  = ent_addr[head_slot];
    assign mem_wr_size  = ent_size[head_slot];
    assign mem_wr_data  = ent_data[head_slot];

    assign alloc_ok = !full;
    assign alloc_id = tail_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_kind_q <= LD_CLEAR;
            res_data   <= '0;
        end else begin
            res_valid <= ld_valid;
            if (ld_valid) begin
                res_kind_q <= srch_kind;
                res_data   <= srch_data;
            end
        end
    end

    assign res_kind = res_kind_q;

endmodule

// File: rtl/sbc_store_buffer_chk.sv
module sbc_store_buffer_chk
    import sbc_pkg::*;
#(
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned ID_W  = $clog2(2 * DEPTH),
    localparam int unsigned NIDS  = 2 * DEPTH
) (
    input logic            clk,
    input logic            rst,
    input logic            alloc_req,
    input logic            alloc_ok,
    input logic [ID_W-1:0] alloc_id,
    input logic            flush,
    input logic            ld_valid,
    input logic            res_valid,
    input logic [1:0]      res_kind,
    input logic            bus_idle,
    input logic            mem_wr_valid
);
    // R1: granted allocations hand out consecutive identifiers
    a_r1_ids_step: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && alloc_ok && !flush) |=> (alloc_id == ID_W'(wrap_inc(32'($past(alloc_id)), NIDS))));

    // R1: a refused request leaves the buffer full when nothing drains
    a_r1_full_holds: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_ok && !flush && !mem_wr_valid) |=> !alloc_ok);

    // R2: each load lookup produces exactly one result a cycle later
    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> res_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !res_valid);

    // R2: result code is one of the three defined values
    a_r2_kind_legal: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_kind != 2'd3));

    // R8: a write leaves only on an idle bus or a full buffer
    a_r8_drain_gate: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> (bus_idle || !alloc_ok));

endmodule

bind sbc_store_buffer sbc_store_buffer_chk #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_sbc_store_buffer.sv
module tb_sbc_store_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 12;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;
    localparam int ID_W   = 5;

    localparam logic [1:0] K_CLEAR = 2'd0;
    localparam logic [1:0] K_FWD   = 2'd1;
    localparam logic [1:0] K_BLOCK = 2'd2;

    localparam logic [63:0] D0 = 64'h1111_2222_3333_4444;
    localparam logic [63:0] D1 = 64'hAAAA_BBBB_CCCC_DDDD;
    localparam logic [63:0] D2 = 64'h5555_6666_7777_8888;
    localparam logic [63:0] D3 = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_req = 0, sta_valid = 0, std_valid = 0, ret_valid = 0, flush = 0, ld_valid = 0, bus_idle = 0;
    logic [ID_W-1:0]   sta_id = '0, std_id = '0, ld_color = '0;
    logic [ADDR_W-1:0] sta_addr = '0, ld_addr = '0;
    logic [1:0]        sta_size = '0, ld_size = '0;
    logic [DATA_W-1:0] std_data = '0;
    logic              alloc_ok, res_valid, mem_wr_valid;
    logic [ID_W-1:0]   alloc_id;
    logic [1:0]        res_kind, mem_wr_size;
    logic [DATA_W-1:0] res_data, mem_wr_data;
    logic [ADDR_W-1:0] mem_wr_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_id(alloc_id),
        .sta_valid(sta_valid), .sta_id(sta_id), .sta_addr(sta_addr), .sta_size(sta_size),
        .std_valid(std_valid), .std_id(std_id), .std_data(std_data),
        .ret_valid(ret_valid), .flush(flush),
        .ld_valid(ld_valid), .ld_color(ld_color), .ld_addr(ld_addr), .ld_size(ld_size),
        .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data),
        .bus_idle(bus_idle),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_size(mem_wr_size), .mem_wr_data(mem_wr_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic alloc_one(input logic [ID_W-1:0] exp_id, input string tag);
        check({tag, " alloc_ok"}, 64'(alloc_ok), 64'd1);
        check({tag, " alloc_id"}, 64'(alloc_id), 64'(exp_id));
        alloc_req = 1'b1;
        tick();
        alloc_req = 1'b0;
    endtask

    task automatic give_addr(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input logic [1:0] sz);
        sta_valid = 1'b1; sta_id = id; sta_addr = a; sta_size = sz;
        tick();
        sta_valid = 1'b0;
    endtask

    task automatic give_data(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d);
        std_valid = 1'b1; std_id = id; std_data = d;
        tick();
        std_valid = 1'b0;
    endtask

    task automatic retire_one();
        ret_valid = 1'b1;
        tick();
        ret_valid = 1'b0;
    endtask

    task automatic load_check(input logic [ID_W-1:0] color, input logic [ADDR_W-1:0] a,
                              input logic [1:0] sz, input logic [1:0] exp_kind,
                              input logic [DATA_W-1:0] exp_data, input string tag);
        ld_valid = 1'b1; ld_color = color; ld_addr = a; ld_size = sz;
        tick();
        ld_valid = 1'b0;
        check({tag, " res_valid"}, 64'(res_valid), 64'd1);
        check({tag, " res_kind"},  64'(res_kind),  64'(exp_kind));
        check({tag, " res_data"},  res_data,       exp_data);
    endtask

    task automatic t_reset();
        check("R1 reset alloc_ok", 64'(alloc_ok), 64'd1);
        check("R1 reset alloc_id", 64'(alloc_id), 64'd0);
        check("R2 reset res_valid", 64'(res_valid), 64'd0);
        check("R8 reset mem_wr_valid", 64'(mem_wr_valid), 64'd0);
    endtask

    task automatic t_forward_rules();
        alloc_one(5'd0, "R1 first store");
        give_addr(5'd0, 16'h0100, 2'd2);
        give_data(5'd0, D0);
        load_check(5'd0, 16'h0100, 2'd2, K_FWD, 64'h0000_0000_3333_4444, "R4 same size fwd");
        load_check(5'd0, 16'h0100, 2'd1, K_FWD, 64'h0000_0000_0000_4444, "R4 smaller fwd");
        load_check(5'd0, 16'h0100, 2'd3, K_BLOCK, 64'd0, "R5 larger load");
        load_check(5'd0, 16'h0102, 2'd0, K_BLOCK, 64'd0, "R5 offset overlap");
        load_check(5'd0, 16'h0104, 2'd2, K_CLEAR, 64'd0, "R4 adjacent clear");
    endtask

    task automatic t_color_window();
        // color 23 names a store allocated before identifier 0
        load_check(5'd23, 16'h0100, 2'd2, K_CLEAR, 64'd0, "R3 younger store ignored");
    endtask

    task automatic t_pending_parts();
        alloc_one(5'd1, "R1 second store");
        load_check(5'd1, 16'h0200, 2'd3, K_BLOCK, 64'd0, "R6 unknown address");
        give_addr(5'd1, 16'h0200, 2'd3);
        load_check(5'd1, 16'h0200, 2'd3, K_BLOCK, 64'd0, "R6 unknown data");
        give_data(5'd1, D1);
        load_check(5'd1, 16'h0200, 2'd3, K_FWD, D1, "R4 full width fwd");
        load_check(5'd0, 16'h0200, 2'd3, K_CLEAR, 64'd0, "R3 color excludes store 1");
    endtask

    task automatic t_youngest();
        alloc_one(5'd2, "R1 third store");
        give_addr(5'd2, 16'h0100, 2'd3);
        give_data(5'd2, D2);
        load_check(5'd2, 16'h0100, 2'd2, K_FWD, 64'h0000_0000_7777_8888, "R7 youngest supplies");
        load_check(5'd1, 16'h0100, 2'd2, K_FWD, 64'h0000_0000_3333_4444, "R7 older color picks store 0");
    endtask

    task automatic t_senior_drain();
        bus_idle = 1'b1;
        #1 check("R9 idle bus no senior", 64'(mem_wr_valid), 64'd0);
        tick();
        check("R9 still nothing written", 64'(mem_wr_valid), 64'd0);
        bus_idle = 1'b0;
        retire_one();
        retire_one();
        check("R8 busy bus holds seniors", 64'(mem_wr_valid), 64'd0);
        bus_idle = 1'b1;
        #1;
        check("R8 first write valid", 64'(mem_wr_valid), 64'd1);
        check("R8 first write addr", 64'(mem_wr_addr), 64'h0100);
        check("R8 first write size", 64'(mem_wr_size), 64'd2);
        check("R8 first write data", mem_wr_data, D0);
        tick();
        check("R8 second write valid", 64'(mem_wr_valid), 64'd1);
        check("R8 second write addr", 64'(mem_wr_addr), 64'h0200);
        check("R8 second write data", mem_wr_data, D1);
        tick();
        check("R9 unretired store stays", 64'(mem_wr_valid), 64'd0);
        bus_idle = 1'b0;
    endtask

    task automatic t_flush();
        retire_one();
        alloc_one(5'd3, "R10 speculative store a");
        give_addr(5'd3, 16'h0300, 2'd3);
        alloc_one(5'd4, "R10 speculative store b");
        flush = 1'b1;
        tick();
        flush = 1'b0;
        check("R10 rewind alloc_id", 64'(alloc_id), 64'd3);
        load_check(5'd4, 16'h0300, 2'd3, K_CLEAR, 64'd0, "R10 flushed store gone");
        load_check(5'd4, 16'h0100, 2'd3, K_FWD, D2, "R10 senior kept");
        bus_idle = 1'b1;
        #1;
        check("R10 senior drains", 64'(mem_wr_valid), 64'd1);
        check("R10 senior drain data", mem_wr_data, D2);
        tick();
        bus_idle = 1'b0;
        check("R10 nothing left", 64'(mem_wr_valid), 64'd0);
    endtask

    task automatic t_full_wrap();
        for (int k = 0; k < DEPTH; k++)
            alloc_one(ID_W'((3 + k) % (2 * DEPTH)), "R1 fill");
        check("R1 full alloc_ok", 64'(alloc_ok), 64'd0);
        alloc_req = 1'b1;
        tick();
        alloc_req = 1'b0;
        check("R1 refused keeps full", 64'(alloc_ok), 64'd0);
        check("R1 refused keeps id", 64'(alloc_id), 64'd15);
        give_addr(5'd3, 16'h0400, 2'd3);
        give_data(5'd3, D3);
        retire_one();
        #1;
        check("R8 full forces write", 64'(mem_wr_valid), 64'd1);
        check("R8 full write addr", 64'(mem_wr_addr), 64'h0400);
        check("R8 full write data", mem_wr_data, D3);
        tick();
        check("R8 write stops after", 64'(mem_wr_valid), 64'd0);
        alloc_one(5'd15, "R1 wrapped id");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_forward_rules();
        t_color_window();
        t_pending_parts();
        t_youngest();
        t_senior_drain();
        t_flush();
        t_full_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule